// File: doc/BRIEF.md
# Inbound DMA Protected-Range Filter

This block sits on the path that device-initiated memory requests take into system memory. Graphics engines and other bus masters are all treated alike. Each request carries a start address and a length. The block compares the span against a set of protected windows and either grants the request or rejects it with an error response.

There are three windows. One segment window is meant to cover the management-mode memory. Two generic windows, numbered 0 and 1, can guard any other region. Every window is a base and a limit, and both bounds are inclusive. A window whose base is above its limit is switched off.

Firmware programs the windows through a small write port. It then sets a lock bit, after which the windows can no longer be moved until reset. Without the lock, malicious software could slide the segment window away from the memory it is supposed to guard. The first address that is ever rejected is kept in a sticky status register.

Control is a three-state machine:
- IDLE is the only state that accepts a request.
- EVAL registers the decision.
- REPLY presents the response for one cycle.

The transitions are:
- IDLE to EVAL on an accepted request.
- EVAL to REPLY unconditionally.
- REPLY to IDLE unconditionally.

Top module: `dma_range_guard`

## Requirements
- R1: After reset the filter is IDLE with `req_ready` high, `rsp_valid` low, `viol_flag` low and `cfg_locked` low. Every window is switched off at reset (base all ones, limit zero), so any request is granted.
- R2: A request whose span touches any byte from the segment window's base through its limit, both inclusive, is blocked. A span lying wholly below the base or above the limit is granted.
- R3: Generic windows 0 and 1 each block spans that overlap them, independently of each other and of the segment window.
- R4: A window with base greater than limit matches nothing. A window with base equal to limit guards exactly that one byte.
- R5: `req_len` holds the byte count minus one, so the span covers `req_addr` through `req_addr + req_len`. A span that starts outside a window but whose last byte reaches into it is blocked.
- R6: Writing a value with bit 0 set to register index 6 raises `cfg_locked`. From then until reset, writes to every window register and to the lock are ignored.
- R7: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low for the next two cycles. `rsp_valid` is high in exactly the second cycle after acceptance, and in that cycle exactly one of `rsp_grant` and `rsp_block` is high.
- R8: The first blocked request sets `viol_flag` and loads its start address into `viol_addr`. Both then hold until reset: granted requests and later blocks leave them unchanged.
- R9: The write port indices are assigned as follows.

  | Index | Register |
  | --- | --- |
  | 0 | Segment window base |
  | 1 | Segment window limit |
  | 2 | Generic window 0 base |
  | 3 | Generic window 0 limit |
  | 4 | Generic window 1 base |
  | 5 | Generic window 1 limit |
  | 6 | Lock |

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index (R9) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_locked | output | 1 | Configuration lock state |
| req_valid | input | 1 | Inbound request strobe |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | 32 | Request start address |
| req_len | input | 12 | Request byte count minus one |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Request allowed |
| rsp_block | output | 1 | Request rejected (error response) |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 32 | Start address of the first blocked request |

## Verification
The assertions watch the following on every cycle:
- The handshake and response timing.
- That a response is exactly one of grant or block.
- That a block always leaves the violation flag set.
- That the lock, the window registers once locked, and the captured violation address never change.

Whether a particular address is blocked, and how inclusive limits, disabled windows and multi-byte spans behave, depend on the programmed values. Only the bench's scenarios can show these.

// File: rtl/drg_pkg.sv
package drg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_REPLY = 2'd2
    } drg_state_t;
endpackage

// File: rtl/drg_cfg_regs.sv
module drg_cfg_regs #(
    parameter int AW = 32,
    parameter int NR = 3,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] base_o  [NR],
    output logic [AW-1:0] limit_o [NR],
    output logic          locked_o
);
    localparam int LOCK_IDX = 2 * NR;

    logic locked_q;
    logic wr_ok;

    assign wr_ok    = cfg_we && !locked_q;
    assign locked_o = locked_q;

    for (genvar r = 0; r < NR; r++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[r]  <= '1;
                limit_o[r] <= '0;
            end else begin
                if (wr_ok && cfg_idx == IW'(2 * r))
                    base_o[r] <= cfg_wdata;
                if (wr_ok && cfg_idx == IW'(2 * r + 1))
                    limit_o[r] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (wr_ok && cfg_idx == IW'(LOCK_IDX))
            locked_q <= cfg_wdata[0];
    end
endmodule

// File: rtl/drg_range_hit.sv
module drg_range_hit #(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] len,
    output logic          hit
);
    localparam int EW = AW + 1;

    logic [EW-1:0] span_end;
    logic          enabled;

    // Widened to EW bits so that a span crossing the top of the address space does not wrap.
    assign span_end = {1'b0, addr} + {{(EW - LW){1'b0}}, len};
    assign enabled  = (base <= limit);
    assign hit      = enabled && (addr <= limit) && (span_end >= {1'b0, base});
endmodule

// File: rtl/drg_ctrl.sv
module drg_ctrl #(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          any_hit,
    output logic          req_ready,
    output logic [AW-1:0] cap_addr,
    output logic [LW-1:0] cap_len,
    output logic          rsp_valid,
    output logic          rsp_grant,
    output logic          rsp_block,
    output logic          viol_flag,
    output logic [AW-1:0] viol_addr
);
    import drg_pkg::*;

    drg_state_t state_q, state_d;
    logic       blk_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_len   <= '0;
            blk_q     <= 1'b0;
            viol_flag <= 1'b0;
            viol_addr <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                cap_addr <= req_addr;
                cap_len  <= req_len;
            end
            if (state_q == ST_EVAL) begin
                blk_q <= any_hit;
                if (any_hit && !viol_flag) begin
                    viol_flag <= 1'b1;
                    viol_addr <= cap_addr;
                end
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_grant = 1'b0;
        rsp_block = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_EVAL:  ;
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_grant = !blk_q;
                rsp_block = blk_q;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/dma_range_guard.sv
module dma_range_guard #(
    parameter int AW   = 32,
    parameter int LW   = 12,
    parameter int NGEN = 2,
    parameter int NR   = NGEN + 1,
    parameter int IW   = $clog2(2 * NR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_wdata,
    output logic          cfg_locked,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          rsp_valid,
    output logic          rsp_grant,
    output logic          rsp_block,
    output logic          viol_flag,
    output logic [AW-1:0] viol_addr
);
    localparam int FW = NR * 2 * AW;

    logic [AW-1:0] win_base  [NR];
    logic [AW-1:0] win_limit [NR];
    logic [NR-1:0] win_hit;
    logic [AW-1:0] cap_addr;
    logic [LW-1:0] cap_len;
    logic [FW-1:0] cfg_flat;

    drg_cfg_regs #(.AW(AW), .NR(NR), .IW(IW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_wdata(cfg_wdata),
        .base_o   (win_base),
        .limit_o  (win_limit),
        .locked_o (cfg_locked)
    );

    for (genvar r = 0; r < NR; r++) begin : g_cmp
        drg_range_hit #(.AW(AW), .LW(LW)) u_hit (
            .base (win_base[r]),
            .limit(win_limit[r]),
            .addr (cap_addr),
            .len  (cap_len),
            .hit  (win_hit[r])
        );
        assign cfg_flat[r*2*AW +: AW]      = win_base[r];
        assign cfg_flat[r*2*AW + AW +: AW] = win_limit[r];
    end

    drg_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_len  (req_len),
        .any_hit  (|win_hit),
        .req_ready(req_ready),
        .cap_addr (cap_addr),
        .cap_len  (cap_len),
        .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant),
        .rsp_block(rsp_block),
        .viol_flag(viol_flag),
        .viol_addr(viol_addr)
    );
endmodule

// File: rtl/drg_checker.sv
module drg_checker #(
    parameter int AW = 32,
    parameter int FW = 96
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_grant,
    input logic          rsp_block,
    input logic          cfg_locked,
    input logic          viol_flag,
    input logic [AW-1:0] viol_addr,
    input logic [FW-1:0] cfg_flat
);
    // R7
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant != rsp_block));
    // R7
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_block));
    // R7
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid) ##1 (rsp_valid && !req_ready));
    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);
    // R6
    locked_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(cfg_flat));
    // R8
    viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> (viol_flag && $stable(viol_addr)));
    // R8
    block_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_block) |-> viol_flag);
endmodule

bind dma_range_guard drg_checker #(.AW(AW), .FW(NR * 2 * AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_block (rsp_block),
    .cfg_locked(cfg_locked),
    .viol_flag (viol_flag),
    .viol_addr (viol_addr),
    .cfg_flat  (cfg_flat)
);

// File: tb/sim_dma_range_guard.sv
module sim_dma_range_guard;
    localparam int AW = 32;
    localparam int LW = 12;
    localparam int IW = 3;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          cfg_locked;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          rsp_valid, rsp_grant, rsp_block, viol_flag;
    logic [AW-1:0] viol_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_range_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_locked(cfg_locked), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_block(rsp_block),
        .viol_flag(viol_flag), .viol_addr(viol_addr)
    );

    // {addr, len, expect_block}. Windows: segment 0x1000..0x1FFF,
    // generic 0 0x8000..0x80FF, generic 1 0xA000..0xA000 (set via indices 0..5, R9).
    localparam logic [AW+LW:0] VEC [NV] = '{
        {32'h0000_0800, 12'h000, 1'b0},  // R2 below segment
        {32'h0000_1000, 12'h000, 1'b1},  // R2 base inclusive (first violation)
        {32'h0000_1FFF, 12'h000, 1'b1},  // R2 limit inclusive
        {32'h0000_2000, 12'h000, 1'b0},  // R2 above segment
        {32'h0000_0F00, 12'h0FF, 1'b0},  // R5 last byte 0x0FFF
        {32'h0000_0F00, 12'h100, 1'b1},  // R5 last byte 0x1000
        {32'h0000_80FF, 12'h000, 1'b1},  // R3 generic 0 limit
        {32'h0000_8100, 12'h000, 1'b0},  // R3 past generic 0
        {32'h0000_A000, 12'h000, 1'b1},  // R4 one-byte generic 1
        {32'h0000_9FFF, 12'h000, 1'b0},  // R4 byte below
        {32'h0000_A001, 12'h000, 1'b0},  // R4 byte above
        {32'h0000_7F00, 12'hFFF, 1'b1}   // R5 span covers generic 0
    };

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [IW-1:0] idx, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Returns the sampled block bit; also checks R7 timing on request.
    task automatic send_req(input logic [AW-1:0] a, input logic [LW-1:0] l, output logic blk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 busy ready low", {31'd0, req_ready}, 32'd0);
        check("R7 no early response", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        check("R7 response valid", {31'd0, rsp_valid}, 32'd1);
        check("R7 grant xor block", {31'd0, rsp_grant ^ rsp_block}, 32'd1);
        blk = rsp_block;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 viol_flag", {31'd0, viol_flag}, 32'd0);
        check("R1 locked", {31'd0, cfg_locked}, 32'd0);
        send_req(32'h0, 12'hFFF, b);
        check("R1 all windows off", {31'd0, b}, 32'd0);
        check("R1 grant leaves viol clear", {31'd0, viol_flag}, 32'd0);

        // R9 register map
        write_cfg(3'd0, 32'h1000); write_cfg(3'd1, 32'h1FFF);
        write_cfg(3'd2, 32'h8000); write_cfg(3'd3, 32'h80FF);
        write_cfg(3'd4, 32'hA000); write_cfg(3'd5, 32'hA000);

        for (int i = 0; i < NV; i++) begin
            send_req(VEC[i][AW+LW:LW+1], VEC[i][LW:1], b);
            check($sformatf("R2/R3/R4/R5 vector %0d", i), {31'd0, b}, {31'd0, VEC[i][0]});
        end

        // R8 first violation kept
        check("R8 viol_flag", {31'd0, viol_flag}, 32'd1);
        check("R8 viol_addr first", viol_addr, 32'h1000);

        // R4 disable generic 0 by base > limit
        write_cfg(3'd2, 32'h8100);
        send_req(32'h8000, 12'h0, b);
        check("R4 disabled window", {31'd0, b}, 32'd0);

        // R6 lock
        write_cfg(3'd6, 32'h1);
        check("R6 locked", {31'd0, cfg_locked}, 32'd1);
        write_cfg(3'd1, 32'h0);
        send_req(32'h1500, 12'h0, b);
        check("R6 segment limit write ignored", {31'd0, b}, 32'd1);
        write_cfg(3'd2, 32'h8000);
        send_req(32'h8000, 12'h0, b);
        check("R6 generic base write ignored", {31'd0, b}, 32'd0);
        write_cfg(3'd6, 32'h0);
        check("R6 unlock ignored", {31'd0, cfg_locked}, 32'd1);
        check("R8 viol_addr unchanged", viol_addr, 32'h1000);

        // R1 reset clears lock and status, R6 until reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 locked after reset", {31'd0, cfg_locked}, 32'd0);
        check("R1 viol after reset", {31'd0, viol_flag}, 32'd0);
        send_req(32'h1500, 12'h0, b);
        check("R1 windows off after reset", {31'd0, b}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule